// File: doc/BRIEF.md
# Interrupt Vector Ring Producer

This block turns interrupt events from client sources into fixed 32-byte vectors and stores them in a circular buffer in memory that software drains. Events enter through a small valid/ready queue. The block then issues each vector as eight consecutive 32-bit write beats on a simple memory write port. Once the eighth beat is out, it advances its byte-offset write pointer.

Software programs the block through a small register bus. Through that bus it sets the ring base address, the ring size and the control bits, and it moves the read pointer. The read pointer can also be moved by a doorbell write that matches a programmed offset. When advancing the write pointer would land on the read pointer, the block can refuse the vector and raise a sticky overflow flag. If writeback is enabled, every committed vector is followed by one extra beat that copies the write-pointer register to a programmed address. An interrupt line stays high while enabled entries remain unread.

Register offsets on the bus are: 0 control, 1 ring base address, 2 read pointer, 3 write pointer (bit 31 is the overflow flag, and writes to it are ignored), 4 writeback address, 5 doorbell (offset in the low bits, enable in bit 16).

Top module: `ivr_producer`

## Requirements
- R1: Each vector is eight beats at consecutive word addresses starting at ring base plus write pointer. Beat 0 is {vmid_src[31], 3'b0, vmid[27:24], ring[23:16], source[15:8], client[7:0]}. Beat 1 is stamp[31:0] and beat 2 is {16'b0, stamp[47:32]}. Beat 3 is {16'b0, pasid}, and beats 4 to 7 are the four event data words, low word first.
- R2: After the eighth beat, the write pointer becomes (wptr + 32) AND mask. The ring holds 4 << size bytes, where size is control bits 6:2.
- R3: With overflow detection on (control bit 7), a vector is dropped when (wptr + 32) AND mask equals the read pointer. A dropped vector issues no memory beat, leaves the write pointer unchanged, and sets write-pointer register bit 31.
- R4: Write-pointer register bit 31 stays set until a control write carries bit 8 = 1. Bit 8 is not stored.
- R5: With overflow detection off, a vector meeting the full condition is still written and the write pointer still advances.
- R6: Vectors are issued only while ring enable (control bit 0) and interrupt enable (control bit 1) are both 1. Until then, queued events wait. While ring enable is 0, both pointers read 0.
- R7: With writeback enable (control bit 9) set, each committed vector is followed by one beat to the writeback address carrying {overflow flag, write pointer}. With it clear, no such beat is issued.
- R8: A write to register 2 sets the read pointer to the written value AND mask, with bits 4:0 cleared.
- R9: A doorbell updates the read pointer only when doorbell register bit 16 is 1 and the doorbell index equals doorbell register bits DB_W-1:0. Any other doorbell is ignored.
- R10: `irq` is 1 exactly when ring enable and interrupt enable are 1 and the read pointer differs from the write pointer. It therefore stays high after a read-pointer write that leaves entries unread.
- R11: The input queue holds QDEPTH events, and `ev_ready` is 0 only while it is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| db_valid | input | 1 | Doorbell write strobe |
| db_index | input | DB_W | Doorbell index |
| db_data | input | 32 | Doorbell read-pointer value |
| ev_valid | input | 1 | Event valid |
| ev_ready | output | 1 | Event queue can accept |
| ev_client | input | 8 | Client id |
| ev_source | input | 8 | Source id |
| ev_ring | input | 8 | Ring id |
| ev_vmid | input | 4 | Virtual machine id |
| ev_vmid_src | input | 1 | Vmid source flag |
| ev_pasid | input | 16 | Process address space id |
| ev_stamp | input | 48 | Timestamp |
| ev_data | input | 128 | Four source-data words, word 0 in bits 31:0 |
| mem_valid | output | 1 | Memory write beat valid |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_data | output | 32 | Memory write data |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with QDEPTH = 2 and a 12-bit pointer, and programs a 128-byte ring that holds four vector slots. With the shallow queue, two held events are enough to deassert `ev_ready`. With the short ring, three vectors fill it, so the drop path, the wrap of the write pointer back to zero and the forced write with detection off are all reached within a few dozen events.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
   localparam int VEC_BYTES = 32;
   localparam int VEC_BEATS = 8;

   localparam logic [2:0] OFS_CTRL = 3'd0;
   localparam logic [2:0] OFS_BASE = 3'd1;
   localparam logic [2:0] OFS_RPTR = 3'd2;
   localparam logic [2:0] OFS_WPTR = 3'd3;
   localparam logic [2:0] OFS_WBAD = 3'd4;
   localparam logic [2:0] OFS_DBEL = 3'd5;

   typedef struct packed {
      logic [7:0]        client;
      logic [7:0]        source;
      logic [7:0]        ring;
      logic [3:0]        vmid;
      logic              vmid_src;
      logic [15:0]       pasid;
      logic [47:0]       stamp;
      logic [3:0][31:0]  data;
   } ivr_event_t;

   localparam int EV_W = $bits(ivr_event_t);

   function automatic logic [31:0] vec_word(input ivr_event_t e, input logic [2:0] idx);
      case (idx)
         3'd0:    return {e.vmid_src, 3'b000, e.vmid, e.ring, e.source, e.client};
         3'd1:    return e.stamp[31:0];
         3'd2:    return {16'h0000, e.stamp[47:32]};
         3'd3:    return {16'h0000, e.pasid};
         default: return e.data[idx[1:0]];
      endcase
   endfunction
endpackage

// File: rtl/ivr_queue.sv
module ivr_queue #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      push,
   input  logic [W-1:0]              push_data,
   output logic                      can_push,
   input  logic                      pop,
   output logic                      has_data,
   output logic [W-1:0]              head,
   output logic [$clog2(DEPTH+1)-1:0] count
);
   localparam int CW = $clog2(DEPTH + 1);

   assign can_push = (count != CW'(DEPTH));
   assign has_data = (count != '0);

   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] slot;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot  <= '0;
               count <= '0;
            end else begin
               if (push && can_push) slot <= push_data;
               if (push && can_push) count <= 1'b1;
               else if (pop && has_data) count <= 1'b0;
            end
         end
         assign head = slot;
      end else begin : g_ring
         localparam int AW = $clog2(DEPTH);
         logic [W-1:0]  store [DEPTH];
         logic [AW-1:0] wr_i, rd_i;
         logic          do_push, do_pop;
         assign do_push = push && can_push;
         assign do_pop  = pop && has_data;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wr_i  <= '0;
               rd_i  <= '0;
               count <= '0;
            end else begin
               if (do_push) wr_i <= (wr_i == AW'(DEPTH - 1)) ? '0 : wr_i + 1'b1;
               if (do_pop)  rd_i <= (rd_i == AW'(DEPTH - 1)) ? '0 : rd_i + 1'b1;
               if (do_push && !do_pop)      count <= count + 1'b1;
               else if (do_pop && !do_push) count <= count - 1'b1;
            end
         end
         always_ff @(posedge clk) begin
            if (do_push) store[wr_i] <= push_data;
         end
         assign head = store[rd_i];
      end
   endgenerate
endmodule

// File: rtl/ivr_ctrl.sv
module ivr_ctrl
   import ivr_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int PTR_W  = 18,
   parameter int DB_W   = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              db_valid,
   input  logic [DB_W-1:0]   db_index,
   input  logic [31:0]       db_data,
   input  logic              commit,
   input  logic              drop,
   output logic              ring_en,
   output logic              intr_en,
   output logic              ovf_en,
   output logic              wb_en,
   output logic [ADDR_W-1:0] base,
   output logic [ADDR_W-1:0] wb_addr,
   output logic [PTR_W-1:0]  wptr,
   output logic [PTR_W-1:0]  mask,
   output logic              full,
   output logic              ovf,
   output logic              ovf_clr,
   output logic              irq
);
   localparam logic [PTR_W-1:0] ALIGN = {{(PTR_W-5){1'b1}}, 5'b00000};
   localparam logic [PTR_W-1:0] STEP  = PTR_W'(VEC_BYTES);
   localparam logic [PTR_W-1:0] ONES  = '1;

   logic [4:0]       size_lg;
   logic [PTR_W-1:0] rptr, wptr_next;
   logic [DB_W-1:0]  db_off;
   logic             db_en, wr_ctrl, wr_rptr, db_hit;

   always_comb begin
      if ({1'b0, size_lg} >= 6'(PTR_W - 2)) mask = ONES;
      else                                  mask = ~(ONES << ({1'b0, size_lg} + 6'd2));
   end

   assign wptr_next = (wptr + STEP) & mask;
   assign full      = (wptr_next == rptr);
   assign wr_ctrl   = reg_we && (reg_addr == OFS_CTRL);
   assign wr_rptr   = reg_we && (reg_addr == OFS_RPTR);
   assign ovf_clr   = wr_ctrl && reg_wdata[8];
   assign db_hit    = db_valid && db_en && (db_index == db_off);
   assign irq       = ring_en && intr_en && (rptr != wptr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {ring_en, intr_en, ovf_en, wb_en, db_en} <= '0;
         size_lg <= '0;
         base    <= '0;
         wb_addr <= '0;
         db_off  <= '0;
      end else if (reg_we) begin
         case (reg_addr)
            OFS_CTRL: begin
               ring_en <= reg_wdata[0];
               intr_en <= reg_wdata[1];
               size_lg <= reg_wdata[6:2];
               ovf_en  <= reg_wdata[7];
               wb_en   <= reg_wdata[9];
            end
            OFS_BASE: base    <= reg_wdata[ADDR_W-1:0];
            OFS_WBAD: wb_addr <= reg_wdata[ADDR_W-1:0];
            OFS_DBEL: begin
               db_off <= reg_wdata[DB_W-1:0];
               db_en  <= reg_wdata[16];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr <= '0;
         wptr <= '0;
         ovf  <= 1'b0;
      end else begin
         if (drop)         ovf <= 1'b1;
         else if (ovf_clr) ovf <= 1'b0;
         if (!ring_en) begin
            rptr <= '0;
            wptr <= '0;
         end else begin
            if (commit) wptr <= wptr_next;
            if (wr_rptr)     rptr <= reg_wdata[PTR_W-1:0] & mask & ALIGN;
            else if (db_hit) rptr <= db_data[PTR_W-1:0] & mask & ALIGN;
         end
      end
   end

   always_comb begin
      case (reg_addr)
         OFS_CTRL: reg_rdata = {22'd0, wb_en, 1'b0, ovf_en, size_lg, intr_en, ring_en};
         OFS_BASE: reg_rdata = 32'(base);
         OFS_RPTR: reg_rdata = 32'(rptr);
         OFS_WPTR: reg_rdata = {ovf, 31'(wptr)};
         OFS_WBAD: reg_rdata = 32'(wb_addr);
         OFS_DBEL: reg_rdata = {15'd0, db_en, 16'(db_off)};
         default:  reg_rdata = '0;
      endcase
   end

   logic unused_bits;
   assign unused_bits = ^{reg_wdata, db_data};
endmodule

// File: rtl/ivr_writer.sv
module ivr_writer
   import ivr_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int PTR_W  = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              ovf_en,
   input  logic              wb_en,
   input  logic              full,
   input  logic              ovf,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] wb_addr,
   input  logic [PTR_W-1:0]  wptr,
   input  logic              q_valid,
   input  ivr_event_t        q_head,
   output logic              q_pop,
   output logic              commit,
   output logic              drop,
   output logic              mem_valid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_data
);
   typedef enum logic [1:0] {W_IDLE, W_BEAT, W_WBACK} wstate_t;

   wstate_t    st;
   logic [2:0] beat;
   ivr_event_t cur;
   logic [PTR_W-1:0] slot_off;

   assign q_pop     = (st == W_IDLE) && active && q_valid;
   assign drop      = q_pop && full && ovf_en;
   assign commit    = (st == W_BEAT) && active && (beat == 3'(VEC_BEATS - 1));
   assign mem_valid = (st != W_IDLE) && active;

   always_comb begin
      if (st == W_WBACK) begin
         mem_addr = wb_addr;
         mem_data = {ovf, 31'(wptr)};
      end else begin
         mem_addr = base + ADDR_W'(slot_off) + ADDR_W'({beat, 2'b00});
         mem_data = vec_word(cur, beat);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= W_IDLE;
         beat     <= '0;
         cur      <= '0;
         slot_off <= '0;
      end else if (!active) begin
         st <= W_IDLE;
      end else begin
         case (st)
            W_IDLE: if (q_pop && !drop) begin
               cur      <= q_head;
               slot_off <= wptr;
               beat     <= '0;
               st       <= W_BEAT;
            end
            W_BEAT: begin
               beat <= beat + 1'b1;
               if (commit) st <= wb_en ? W_WBACK : W_IDLE;
            end
            default: st <= W_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ivr_producer.sv
module ivr_producer
   import ivr_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int PTR_W  = 18,
   parameter int DB_W   = 10,
   parameter int QDEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              db_valid,
   input  logic [DB_W-1:0]   db_index,
   input  logic [31:0]       db_data,
   input  logic              ev_valid,
   output logic              ev_ready,
   input  logic [7:0]        ev_client,
   input  logic [7:0]        ev_source,
   input  logic [7:0]        ev_ring,
   input  logic [3:0]        ev_vmid,
   input  logic              ev_vmid_src,
   input  logic [15:0]       ev_pasid,
   input  logic [47:0]       ev_stamp,
   input  logic [127:0]      ev_data,
   output logic              mem_valid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_data,
   output logic              irq
);
   localparam int CW = $clog2(QDEPTH + 1);

   generate
      if (PTR_W < 8 || PTR_W > 31) begin : g_bad_ptr
         $error("PTR_W must lie in 8..31");
      end
      if (ADDR_W < PTR_W || ADDR_W > 32) begin : g_bad_addr
         $error("ADDR_W must lie in PTR_W..32");
      end
      if (DB_W < 1 || DB_W > 16) begin : g_bad_db
         $error("DB_W must lie in 1..16");
      end
      if (QDEPTH < 1) begin : g_bad_q
         $error("QDEPTH must be at least 1");
      end
   endgenerate

   ivr_event_t       ev_in, q_head;
   logic             q_valid, q_pop, commit, drop, full, ovf, ovf_clr;
   logic             ring_en, intr_en, ovf_en, wb_en;
   logic [ADDR_W-1:0] base, wb_addr;
   logic [PTR_W-1:0] wptr, mask;
   logic [CW-1:0]    q_count;

   always_comb begin
      ev_in.client   = ev_client;
      ev_in.source   = ev_source;
      ev_in.ring     = ev_ring;
      ev_in.vmid     = ev_vmid;
      ev_in.vmid_src = ev_vmid_src;
      ev_in.pasid    = ev_pasid;
      ev_in.stamp    = ev_stamp;
      ev_in.data     = ev_data;
   end

   ivr_queue #(.W(EV_W), .DEPTH(QDEPTH)) u_queue (
      .clk, .rst_n,
      .push(ev_valid), .push_data(ev_in), .can_push(ev_ready),
      .pop(q_pop), .has_data(q_valid), .head(q_head), .count(q_count)
   );

   ivr_ctrl #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .DB_W(DB_W)) u_ctrl (
      .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
      .db_valid, .db_index, .db_data, .commit, .drop,
      .ring_en, .intr_en, .ovf_en, .wb_en, .base, .wb_addr,
      .wptr, .mask, .full, .ovf, .ovf_clr, .irq
   );

   ivr_writer #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_writer (
      .clk, .rst_n, .active(ring_en && intr_en), .ovf_en, .wb_en, .full, .ovf,
      .base, .wb_addr, .wptr, .q_valid, .q_head, .q_pop, .commit, .drop,
      .mem_valid, .mem_addr, .mem_data
   );
endmodule

// File: rtl/ivr_producer_chk.sv
module ivr_producer_chk #(
   parameter int PTR_W  = 18,
   parameter int QDEPTH = 4
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        ring_en,
   input logic                        intr_en,
   input logic [PTR_W-1:0]            wptr,
   input logic [PTR_W-1:0]            mask,
   input logic                        drop,
   input logic                        ovf,
   input logic                        ovf_clr,
   input logic                        mem_valid,
   input logic                        ev_ready,
   input logic [$clog2(QDEPTH+1)-1:0] q_count
);
   // R2
   wptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ring_en && $past(ring_en) && wptr != $past(wptr))
         |-> wptr == (($past(wptr) + PTR_W'(32)) & $past(mask)));
   // R3
   drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drop && ring_en) |=> wptr == $past(wptr));
   // R3
   drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> ovf);
   // R4
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !ovf_clr) |=> ovf);
   // R6
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ring_en && intr_en) |-> !mem_valid);
   // R6
   off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ring_en |=> wptr == '0);
   // R11
   ready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_ready |-> q_count == ($clog2(QDEPTH+1))'(QDEPTH));
endmodule

bind ivr_producer ivr_producer_chk #(.PTR_W(PTR_W), .QDEPTH(QDEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .ring_en(ring_en), .intr_en(intr_en),
   .wptr(wptr), .mask(mask), .drop(drop), .ovf(ovf), .ovf_clr(ovf_clr),
   .mem_valid(mem_valid), .ev_ready(ev_ready), .q_count(q_count)
);

// File: tb/ivr_producer_bench.sv
`timescale 1ns/1ps
module ivr_producer_bench;
   localparam int ADDR_W = 32;
   localparam int PTR_W  = 12;
   localparam int DB_W   = 10;
   localparam int QDEPTH = 2;
   localparam logic [31:0] BASE = 32'h1000_0000;
   localparam logic [31:0] WBA  = 32'h2000_0040;
   localparam logic [31:0] CTRL_RUN = 32'h297; // ring, intr, size 5, ovf det, writeback

   typedef struct packed {
      logic [7:0]  client;
      logic [7:0]  source;
      logic [7:0]  ring;
      logic [3:0]  vmid;
      logic        vsrc;
      logic [15:0] pasid;
      logic [47:0] stamp;
      logic [31:0] d0;
      logic [31:0] exp_wptr;
   } vec_t;

   localparam vec_t TABLE [3] = '{
      '{8'h12, 8'h34, 8'h56, 4'h7, 1'b1, 16'hBEEF, 48'hA1B2_C3D4_E5F6, 32'h0000_1000, 32'd32},
      '{8'hFF, 8'h00, 8'hAA, 4'h0, 1'b0, 16'h0001, 48'h0000_0000_0001, 32'hFFFF_FFF0, 32'd64},
      '{8'h01, 8'h80, 8'h7F, 4'hF, 1'b1, 16'h8000, 48'hFFFF_0000_FFFF, 32'h5A5A_5A5A, 32'd96}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_we = 1'b0; logic [2:0] reg_addr = '0; logic [31:0] reg_wdata = '0; logic [31:0] reg_rdata;
   logic db_valid = 1'b0; logic [DB_W-1:0] db_index = '0; logic [31:0] db_data = '0;
   logic ev_valid = 1'b0; logic ev_ready;
   logic [7:0] ev_client = '0, ev_source = '0, ev_ring = '0;
   logic [3:0] ev_vmid = '0; logic ev_vmid_src = 1'b0; logic [15:0] ev_pasid = '0;
   logic [47:0] ev_stamp = '0; logic [127:0] ev_data = '0;
   logic mem_valid; logic [ADDR_W-1:0] mem_addr; logic [31:0] mem_data; logic irq;

   always #10 clk = ~clk;

   ivr_producer #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .DB_W(DB_W), .QDEPTH(QDEPTH)) u_ivr_producer (.*);

   int checks = 0, failures = 0;
   logic [31:0] cap_a [128];
   logic [31:0] cap_d [128];
   int cap_n = 0;

   always @(negedge clk) begin
      if (mem_valid && cap_n < 128) begin
         cap_a[cap_n] = mem_addr;
         cap_d[cap_n] = mem_data;
         cap_n = cap_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_we = 1'b0;
      idle(1);
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      @(negedge clk); reg_addr = a; #1; v = reg_rdata;
   endtask

   task automatic bell(input logic [DB_W-1:0] idx, input logic [31:0] d);
      @(negedge clk); db_valid = 1'b1; db_index = idx; db_data = d;
      @(negedge clk); db_valid = 1'b0;
      idle(1);
   endtask

   task automatic send(input vec_t v);
      @(negedge clk);
      ev_client = v.client; ev_source = v.source; ev_ring = v.ring; ev_vmid = v.vmid;
      ev_vmid_src = v.vsrc; ev_pasid = v.pasid; ev_stamp = v.stamp;
      ev_data = {v.d0 + 32'd3, v.d0 + 32'd2, v.d0 + 32'd1, v.d0};
      ev_valid = 1'b1;
      while (!ev_ready) @(negedge clk);
      @(posedge clk); #1; ev_valid = 1'b0;
   endtask

   function automatic logic [31:0] exp_word(input vec_t v, input int k);
      case (k)
         0: return {v.vsrc, 3'b000, v.vmid, v.ring, v.source, v.client};
         1: return v.stamp[31:0];
         2: return {16'h0, v.stamp[47:32]};
         3: return {16'h0, v.pasid};
         default: return v.d0 + 32'(k - 4);
      endcase
   endfunction

   // R1: eight beats of one vector starting at capture index first
   task automatic check_vec(input int first, input logic [31:0] off, input vec_t v);
      for (int k = 0; k < 8; k++) begin
         chk(cap_a[first+k] == BASE + off + 32'(4*k), "R1 addr", cap_a[first+k], BASE + off + 32'(4*k));
         chk(cap_d[first+k] == exp_word(v, k), "R1 data", cap_d[first+k], exp_word(v, k));
      end
   endtask

   logic [31:0] v;
   int n0;
   vec_t extra;

   initial begin
      #(200000 * 20);
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      extra = '{8'h99, 8'h88, 8'h77, 4'h6, 1'b0, 16'h4242, 48'h0102_0304_0506, 32'hC0DE_0000, 32'd0};
      idle(3); rst_n = 1'b1; idle(1);
      // reset state
      rd(3'd3, v); chk(v == 0, "R2 reset wptr", v, 0);
      rd(3'd2, v); chk(v == 0, "R8 reset rptr", v, 0);
      chk(irq == 1'b0, "R10 reset irq", 32'(irq), 0);
      chk(ev_ready == 1'b1, "R11 reset ready", 32'(ev_ready), 1);
      chk(mem_valid == 1'b0, "R6 reset mem", 32'(mem_valid), 0);

      wr(3'd1, BASE); wr(3'd4, WBA); wr(3'd0, CTRL_RUN);

      // table walk: three vectors fill a 128-byte ring
      for (int i = 0; i < 3; i++) begin
         n0 = cap_n;
         send(TABLE[i]); idle(20);
         chk(cap_n == n0 + 9, "R7 beat count", 32'(cap_n - n0), 9);
         check_vec(n0, (i == 0) ? 32'd0 : TABLE[i-1].exp_wptr, TABLE[i]);
         chk(cap_a[n0+8] == WBA, "R7 wb addr", cap_a[n0+8], WBA);
         chk(cap_d[n0+8] == TABLE[i].exp_wptr, "R7 wb data", cap_d[n0+8], TABLE[i].exp_wptr);
         rd(3'd3, v); chk(v == TABLE[i].exp_wptr, "R2 wptr step", v, TABLE[i].exp_wptr);
         chk(irq == 1'b1, "R10 irq pending", 32'(irq), 1);
      end

      // R3: ring full, vector dropped
      n0 = cap_n;
      send(extra); idle(20);
      chk(cap_n == n0, "R3 no beats", 32'(cap_n - n0), 0);
      rd(3'd3, v); chk(v == 32'h8000_0060, "R3 overflow flag", v, 32'h8000_0060);
      // R4: sticky, then cleared by control bit 8
      idle(10);
      rd(3'd3, v); chk(v == 32'h8000_0060, "R4 sticky", v, 32'h8000_0060);
      wr(3'd0, CTRL_RUN | 32'h100);
      rd(3'd3, v); chk(v == 32'h60, "R4 cleared", v, 32'h60);
      rd(3'd0, v); chk(v == CTRL_RUN, "R4 bit8 not stored", v, CTRL_RUN);

      // R8 / R10: read pointer writes
      wr(3'd2, 32'h45);
      rd(3'd2, v); chk(v == 32'h40, "R8 aligned rptr", v, 32'h40);
      chk(irq == 1'b1, "R10 rearm", 32'(irq), 1);
      wr(3'd2, 32'h60);
      chk(irq == 1'b0, "R10 drained", 32'(irq), 0);

      // R9: doorbell
      wr(3'd5, 32'h0001_0005);
      bell(10'd4, 32'h20);
      rd(3'd2, v); chk(v == 32'h60, "R9 index mismatch ignored", v, 32'h60);
      bell(10'd5, 32'h20);
      rd(3'd2, v); chk(v == 32'h20, "R9 doorbell hit", v, 32'h20);
      wr(3'd5, 32'h0000_0005);
      bell(10'd5, 32'h40);
      rd(3'd2, v); chk(v == 32'h20, "R9 disabled ignored", v, 32'h20);
      wr(3'd2, 32'h60);

      // R2 wrap: write at offset 96, pointer returns to 0
      n0 = cap_n;
      send(extra); idle(20);
      check_vec(n0, 32'd96, extra);
      rd(3'd3, v); chk(v == 0, "R2 wrap", v, 0);

      // R5: detection off, full ring still written
      wr(3'd2, 32'h20);
      wr(3'd0, 32'h217);
      n0 = cap_n;
      send(TABLE[0]); idle(20);
      chk(cap_n == n0 + 9, "R5 written when full", 32'(cap_n - n0), 9);
      rd(3'd3, v); chk(v == 32'h20, "R5 advanced no flag", v, 32'h20);

      // R6: interrupt enable off holds events, ring off zeroes pointers
      wr(3'd0, 32'h295);
      n0 = cap_n;
      send(TABLE[1]); idle(20);
      chk(cap_n == n0, "R6 held while disabled", 32'(cap_n - n0), 0);
      wr(3'd0, 32'h294); idle(2);
      rd(3'd3, v); chk(v == 0, "R6 wptr zero", v, 0);
      rd(3'd2, v); chk(v == 0, "R6 rptr zero", v, 0);
      // R7: writeback off -> eight beats only
      wr(3'd0, 32'h097); idle(20);
      chk(cap_n == n0 + 8, "R7 no wb beat", 32'(cap_n - n0), 8);
      check_vec(n0, 32'd0, TABLE[1]);
      rd(3'd3, v); chk(v == 32'h20, "R6 resumed", v, 32'h20);

      // R11: queue full deasserts ready
      wr(3'd0, 32'h095);
      send(TABLE[2]); send(extra); idle(2);
      chk(ev_ready == 1'b0, "R11 ready low when full", 32'(ev_ready), 0);
      wr(3'd0, 32'h097); idle(40);
      chk(ev_ready == 1'b1, "R11 ready after drain", 32'(ev_ready), 1);
      rd(3'd3, v); chk(v == 32'h60, "R11 both vectors written", v, 32'h60);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule